// File: doc/BRIEF.md
# Edge-Latched Interrupt Cause Collector

This block sits beside a serial controller. It turns the controller's twelve level status flags into sticky interrupt causes and one interrupt line. Each flag is watched for a low-to-high change. When a flag rises, its cause bit is latched and stays set after the flag falls, until software clears it by writing a one to that bit. An enable mask selects which causes drive the interrupt line. The line is a registered OR of the enabled causes.

Software reaches the block through a small register port. The port is a write strobe, a 2-bit register select, write data and combinational read data. Through it, software reads the live flag levels, reads and clears the latched causes, and reads and writes the enable mask.

Because only transitions are latched, a flag that is already high when software enables it raises nothing. Software must check the live levels before waiting for an interrupt.

The interrupt line is held by a two-state machine:
- LINE_QUIET → LINE_RAISED when any enabled cause is pending.
- LINE_RAISED → LINE_QUIET when none is pending.
- Each state otherwise holds.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause register reads 0, the enable mask reads 0 and the interrupt line is low. A flag held high through reset and past its release sets no cause.
- R2: A status flag rising from 0 to 1 sets the cause bit at the same position, at the first clock edge that samples it high. The positions are: bit 0 transfer done, 1 transfer ready, 2 receive FIFO ready, 3 send FIFO ready, 4 receive empty, 5 receive full, 6 send empty, 7 send full, 8 receive underflow, 9 receive overflow, 10 send underflow, 11 send overflow. A flag that stays high sets its cause only once.
- R3: A cause bit stays set after its flag falls, for as long as it is not cleared.
- R4: A write to select 1 clears every cause bit whose write-data bit is 1 and leaves the others unchanged. Writing all ones clears every cause.
- R5: If a rising edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: While the enable mask is 0, the interrupt line stays low whatever causes are pending.
- R7: The interrupt line equals the OR of (cause AND mask) as it stood one clock earlier. It goes high one cycle after an enabled cause sets and low one cycle after the last enabled cause clears.
- R8: Reads return the live flags at select 0, the causes at select 1, and the mask at select 2; select 3 reads 0. A write to select 2 loads the mask. Writes to select 0 or 3 change nothing.
- R9: Enabling the mask while a flag is already high, with its cause clear, does not raise the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | 12 | Live status flags from the controller |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 flags, 1 causes, 2 mask, 3 spare) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is a flag edge and a clearing write landing on the same bit in the same clock cycle. The stimulus reaches it by changing the status vector on the same falling edge that presents the clear write, so that both are sampled by the same rising edge. A second hard case is a flag that is already high when the mask is enabled. The stimulus builds it by clearing the cause while the flag stays high and only then enabling the mask, so the line must stay quiet.

// File: rtl/icu_pkg.sv
package icu_pkg;

    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/icu_rise_detect.sv
module icu_rise_detect #(
    parameter int unsigned NFLAG = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] level_i,
    output logic [NFLAG-1:0] rise_o
);

    logic [NFLAG-1:0] prev_q;

    // The previous level resets to ones, so a flag already high at release is not an edge.
    for (genvar g = 0; g < NFLAG; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= level_i[g];
        end
        assign rise_o[g] = level_i[g] & ~prev_q[g];
    end

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & $past(level_i)) == '0)) else $error("rise on a flag that was high"); // R2

endmodule

// File: rtl/icu_cause_bank.sv
module icu_cause_bank #(
    parameter int unsigned NFLAG = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] rise_i,
    input  logic [NFLAG-1:0] clr_i,
    output logic [NFLAG-1:0] cause_o
);

    // A new edge takes priority over a clear in the same cycle.
    for (genvar g = 0; g < NFLAG; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)         cause_o[g] <= 1'b0;
            else if (rise_i[g]) cause_o[g] <= 1'b1;
            else if (clr_i[g])  cause_o[g] <= 1'b0;
        end
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((cause_o & $past(rise_i)) == $past(rise_i))) else $error("edge not latched"); // R2
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_o & ~$past(cause_o) & ~$past(rise_i)) == '0)) else $error("cause set without edge"); // R2
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_o & $past(cause_o & ~clr_i)) == $past(cause_o & ~clr_i))) else $error("cause dropped"); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((cause_o & $past(clr_i & ~rise_i)) == '0)) else $error("clear ignored"); // R4
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & rise_i) != '0) |=> ((cause_o & $past(clr_i & rise_i)) == $past(clr_i & rise_i)))
        else $error("clear won over edge"); // R5

endmodule

// File: rtl/icu_reg_port.sv
module icu_reg_port
    import icu_pkg::*;
#(
    parameter int unsigned NFLAG  = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NFLAG-1:0]  level_i,
    input  logic [NFLAG-1:0]  cause_i,
    output logic [DATA_W-1:0] rdata,
    output logic [NFLAG-1:0]  clr_o,
    output logic [NFLAG-1:0]  mask_o
);

    localparam int unsigned PAD_W = DATA_W - NFLAG;

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    if (PAD_W > 0) begin : g_pad
        logic wdata_unused;
        assign wdata_unused = ^wdata[DATA_W-1:NFLAG];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_o <= '0;
        else if (wr_en && sel == SEL_ENABLE)  mask_o <= wdata[NFLAG-1:0];
    end

    always_comb begin
        clr_o = '0;
        if (wr_en && sel == SEL_CAUSE) clr_o = wdata[NFLAG-1:0];
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_LEVEL:  rdata[NFLAG-1:0] = level_i;
            SEL_CAUSE:  rdata[NFLAG-1:0] = cause_i;
            SEL_ENABLE: rdata[NFLAG-1:0] = mask_o;
            SEL_SPARE:  rdata = '0;
        endcase
    end

    AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd2) |=> $stable(mask_o)) else $error("mask changed without write"); // R8

endmodule

// File: rtl/icu_line_fsm.sv
module icu_line_fsm
    import icu_pkg::*;
#(
    parameter int unsigned NFLAG = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] cause_i,
    input  logic [NFLAG-1:0] mask_i,
    output logic             irq_o
);

    line_state_e state_q, state_d;
    logic        pending;

    assign pending = |(cause_i & mask_i);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending) state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !irq_o) else $error("irq with zero mask"); // R6
    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(cause_i & mask_i))) else $error("irq not tracking causes"); // R7

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
    parameter int unsigned NFLAG  = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAG-1:0]  status_i,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    logic [NFLAG-1:0] rise;
    logic [NFLAG-1:0] clr;
    logic [NFLAG-1:0] cause;
    logic [NFLAG-1:0] mask;

    icu_rise_detect #(.NFLAG(NFLAG)) u_rise (
        .clk(clk), .rst_n(rst_n), .level_i(status_i), .rise_o(rise)
    );

    icu_cause_bank #(.NFLAG(NFLAG)) u_cause (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr), .cause_o(cause)
    );

    icu_reg_port #(.NFLAG(NFLAG), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .level_i(status_i), .cause_i(cause),
        .rdata(reg_rdata), .clr_o(clr), .mask_o(mask)
    );

    icu_line_fsm #(.NFLAG(NFLAG)) u_line (
        .clk(clk), .rst_n(rst_n), .cause_i(cause), .mask_i(mask), .irq_o(irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> !irq_o)
        else $error("irq not low after reset"); // R1

endmodule

// File: tb/tb_irq_cause_unit.sv
`timescale 1ns/100ps
module tb_irq_cause_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] status_i = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit          is_line;
        logic [1:0]  sel;
        logic [31:0] want;
        string       tag;
    } item_t;

    item_t sb_q[$];

    irq_cause_unit dut (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // Driver side: queue the expectation, sampled after the next rising edge.
    task automatic expect_reg(input logic [1:0] sel, input logic [31:0] want, input string tag);
        item_t it;
        reg_addr = sel;
        it.is_line = 1'b0; it.sel = sel; it.want = want; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_line(input logic want, input string tag);
        item_t it;
        it.is_line = 1'b1; it.sel = '0; it.want = {31'd0, want}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        reg_wr_en = 1'b1; reg_addr = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Monitor side: pop one expectation per cycle and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb_q.pop_front();
                got = it.is_line ? {31'd0, irq_o} : reg_rdata;
                checks++;
                if (got !== it.want) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.want);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: transfer-done flag (bit 0) held high through reset
        status_i = 12'h001;
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_reg(2'd1, 32'h0, "R1 cause after reset");         step(1);
        expect_reg(2'd2, 32'h0, "R1 mask after reset");          step(1);
        expect_line(1'b0, "R1 irq after reset");                 step(1);
        expect_reg(2'd0, 32'h001, "R8 live flags at select 0");  step(1);

        // R8: mask load, ignored writes
        reg_write(2'd2, 32'hFFFF_FFFF);
        expect_reg(2'd2, 32'hFFF, "R8 mask readback");           step(1);
        reg_write(2'd0, 32'h0000_0ABC);
        reg_write(2'd3, 32'h0000_0FFF);
        expect_reg(2'd0, 32'h001, "R8 write to select 0 ignored"); step(1);
        expect_reg(2'd3, 32'h0, "R8 select 3 reads zero");       step(1);
        expect_reg(2'd1, 32'h0, "R8 spare write left causes");   step(1);

        // R2 / R7: send FIFO ready (bit 3) rises
        status_i = 12'h000; step(1);
        status_i = 12'h008;
        expect_line(1'b0, "R7 irq not yet high");                step(1);
        expect_line(1'b1, "R7 irq high one cycle later");        step(1);
        expect_reg(2'd1, 32'h008, "R2 cause bit 3 latched");     step(1);

        // R3: flag falls, cause stays
        status_i = 12'h000; step(2);
        expect_reg(2'd1, 32'h008, "R3 cause sticky after fall"); step(1);

        // R4: selective and full clear
        status_i = 12'h0F0; step(2);
        expect_reg(2'd1, 32'h0F8, "R2 bits 4-7 latched");        step(1);
        reg_write(2'd1, 32'h0000_0018);
        expect_reg(2'd1, 32'h0E0, "R4 selective clear");         step(1);
        reg_write(2'd1, 32'hFFFF_FFFF);
        expect_reg(2'd1, 32'h000, "R4 clear all");               step(1);
        expect_line(1'b0, "R7 irq low after clear all");         step(1);
        step(2);
        expect_reg(2'd1, 32'h000, "R2 held flags do not re-set"); step(1);

        // R5: edge on bit 8 and its clear in the same cycle
        status_i = 12'h1F0;
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0100;
        step(1);
        reg_wr_en = 1'b0;
        expect_reg(2'd1, 32'h100, "R5 edge beats clear");        step(1);

        // R6: zero mask holds irq low
        reg_write(2'd2, 32'h0);
        step(1);
        expect_line(1'b0, "R6 irq low with zero mask");          step(1);
        status_i = 12'h9F0; step(2);
        expect_line(1'b0, "R6 new edge, mask zero");             step(1);
        expect_reg(2'd1, 32'h900, "R2 bit 11 latched");          step(1);

        // R9: enable while flags already high and causes clear
        reg_write(2'd1, 32'h0000_0FFF);
        reg_write(2'd2, 32'h0000_0FFF);
        step(2);
        expect_line(1'b0, "R9 no irq for already-high flag");    step(1);
        expect_reg(2'd1, 32'h000, "R9 causes remain clear");     step(1);

        // R7: rise then clear, line follows one cycle behind
        status_i = 12'h9F2; step(2);
        expect_line(1'b1, "R7 irq high for bit 1");              step(1);
        reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0002;
        expect_line(1'b1, "R7 irq still high at clear edge");
        step(1);
        reg_wr_en = 1'b0;
        expect_line(1'b0, "R7 irq low one cycle after clear");   step(1);

        step(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule